// File: doc/BRIEF.md
# Drum Sequencer for Shaft Encoder Compare Events

The block steps through a small programmable table. Each entry pairs a compare value with an output bit pattern. It is placed next to a shaft-position counter. The counter reports two events. A match event fires when its count equals the compare value now handed to it. An index event fires once per revolution and also clears the counter.

On each match the sequencer loads the next entry, so a fresh compare value goes to the counter and a new output pattern is driven. The active pattern therefore covers the stretch of the revolution in which the count stays below the active compare value. An index event rewinds the sequencer to entry 0, and the pattern cycle starts over on each turn of the shaft.

Software fills the table and sets the final entry number while the sequencer is off. Enabling the sequencer starts it at entry 0. After the final entry, the sequencer waits for the next index event.

Top module: `drum_sequencer`

## Requirements
- R1: While rst_ni is low, preset_o, pattern_o and step_o are all zero.
- R2: While enable_i is low, the cycle after it has preset_o = 0, pattern_o = 0 and step_o = 0, and match_i and index_i have no effect.
- R3: In the first cycle in which enable_i is sampled high after being low, the next cycle shows entry 0 (step_o = 0, preset_o and pattern_o from entry 0). The final entry number is captured from last_idx_i in that same cycle.
- R4: A match_i sampled while running, with step_o not equal to the captured final entry number, makes step_o increase by one in the next cycle. preset_o and pattern_o then show the new entry.
- R5: A match_i sampled while step_o equals the captured final entry number is ignored. All outputs hold until an index event.
- R6: An index_i sampled while running makes the next cycle show entry 0.
- R7: When match_i and index_i are sampled high in the same cycle while running, the index wins and entry 0 is loaded.
- R8: A write (wr_en_i with wr_addr_i, wr_preset_i, wr_pattern_i) is stored only in a cycle where enable_i is low. A write while enable_i is high is dropped.
- R9: While running with neither event present, step_o, preset_o and pattern_o hold their values.
- R10: Changes on last_idx_i while running do not change the final entry number until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the sequencer; low stops it and opens the table for writes |
| match_i | input | 1 | Counter's count-equals-compare event |
| index_i | input | 1 | Once-per-revolution index event |
| last_idx_i | input | IDX_W | Final entry number, captured on enable |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | IDX_W | Table entry to write |
| wr_preset_i | input | PW | Compare value to store |
| wr_pattern_i | input | OW | Output pattern to store |
| preset_o | output | PW | Compare value handed to the counter |
| pattern_o | output | OW | Driven output pattern |
| step_o | output | IDX_W | Number of the active entry |

## Verification
The bench targets the following corner cases:
- **Match and index in the same cycle.** A design with the wrong priority would advance to the next entry instead of rewinding.
- **Match at the final entry.** A design that got this wrong would wrap around, or run past the table into stale entries.
- **Writes while running.** Here a rewind must still show the old entry 0; a design that let the write through would show the new values.
- **Final entry number changed while running.** A design that read last_idx_i live would extend the sequence.
- **Enable and index together.** Random enable toggles bring the start-up load and the index together in the same cycle.
- **Events while disabled.** Random events while disabled check that the outputs stay dark.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [2:0] {
    EV_IDLE,
    EV_OFF,
    EV_START,
    EV_REWIND,
    EV_ADVANCE
  } seq_ev_e;
endpackage

// File: rtl/dseq_table.sv
module dseq_table #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PW    = 32,
  parameter int unsigned OW    = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_open_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [PW-1:0]    wr_preset_i,
  input  logic [OW-1:0]    wr_pattern_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [PW-1:0]    rd_preset_o,
  output logic [OW-1:0]    rd_pattern_o
);
  logic [PW-1:0] pre_q [DEPTH];
  logic [OW-1:0] pat_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_open_i && wr_en_i && (wr_addr_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pre_q[g] <= '0;
        pat_q[g] <= '0;
      end else if (hit) begin
        pre_q[g] <= wr_preset_i;
        pat_q[g] <= wr_pattern_i;
      end
    end
  end

  assign rd_preset_o  = pre_q[rd_addr_i];
  assign rd_pattern_o = pat_q[rd_addr_i];
endmodule

// File: rtl/dseq_step.sv
module dseq_step #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             match_i,
  input  logic             index_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             active_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic [IDX_W-1:0] last_o,
  output logic [IDX_W-1:0] nxt_ptr_o,
  output logic             load_o,
  output logic             clear_o
);
  import dseq_pkg::*;

  logic             active_q;
  logic [IDX_W-1:0] ptr_q, last_q, ptr_d;
  seq_ev_e          ev;

  // Priority: stop, start, index, match.
  always_comb begin
    ev = EV_IDLE;
    if (!enable_i)                       ev = EV_OFF;
    else if (!active_q)                  ev = EV_START;
    else if (index_i)                    ev = EV_REWIND;
    else if (match_i && ptr_q != last_q) ev = EV_ADVANCE;
  end

  always_comb begin
    unique case (ev)
      EV_OFF, EV_START, EV_REWIND: ptr_d = '0;
      EV_ADVANCE:                  ptr_d = ptr_q + 1'b1;
      default:                     ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      last_q   <= '0;
    end else begin
      active_q <= enable_i;
      ptr_q    <= ptr_d;
      if (ev == EV_START) last_q <= last_idx_i;
    end
  end

  assign active_o  = active_q;
  assign ptr_o     = ptr_q;
  assign last_o    = last_q;
  assign nxt_ptr_o = ptr_d;
  assign load_o    = (ev == EV_START) || (ev == EV_REWIND) || (ev == EV_ADVANCE);
  assign clear_o   = (ev == EV_OFF);
endmodule

// File: rtl/dseq_out.sv
module dseq_out #(
  parameter int unsigned PW = 32,
  parameter int unsigned OW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clear_i,
  input  logic [PW-1:0] preset_i,
  input  logic [OW-1:0] pattern_i,
  output logic [PW-1:0] preset_o,
  output logic [OW-1:0] pattern_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preset_o  <= '0;
      pattern_o <= '0;
    end else if (clear_i) begin
      preset_o  <= '0;
      pattern_o <= '0;
    end else if (load_i) begin
      preset_o  <= preset_i;
      pattern_o <= pattern_i;
    end
  end
endmodule

// File: rtl/drum_sequencer.sv
module drum_sequencer #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PW    = 32,
  parameter int unsigned OW    = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             match_i,
  input  logic             index_i,
  input  logic [IDX_W-1:0] last_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [PW-1:0]    wr_preset_i,
  input  logic [OW-1:0]    wr_pattern_i,
  output logic [PW-1:0]    preset_o,
  output logic [OW-1:0]    pattern_o,
  output logic [IDX_W-1:0] step_o
);
  logic             active;
  logic [IDX_W-1:0] last_idx, nxt_ptr;
  logic             load, clear;
  logic [PW-1:0]    rd_preset;
  logic [OW-1:0]    rd_pattern;

  dseq_step #(.DEPTH(DEPTH)) i_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .match_i    (match_i),
    .index_i    (index_i),
    .last_idx_i (last_idx_i),
    .active_o   (active),
    .ptr_o      (step_o),
    .last_o     (last_idx),
    .nxt_ptr_o  (nxt_ptr),
    .load_o     (load),
    .clear_o    (clear)
  );

  // The table accepts writes only while the sequencer is stopped.
  dseq_table #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) i_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_open_i    (!enable_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_preset_i  (wr_preset_i),
    .wr_pattern_i (wr_pattern_i),
    .rd_addr_i    (nxt_ptr),
    .rd_preset_o  (rd_preset),
    .rd_pattern_o (rd_pattern)
  );

  dseq_out #(.PW(PW), .OW(OW)) i_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .clear_i   (clear),
    .preset_i  (rd_preset),
    .pattern_i (rd_pattern),
    .preset_o  (preset_o),
    .pattern_o (pattern_o)
  );
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PW    = 32,
  parameter int unsigned OW    = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             match_i,
  input logic             index_i,
  input logic             active_i,
  input logic [IDX_W-1:0] last_i,
  input logic [IDX_W-1:0] step_i,
  input logic [PW-1:0]    preset_i,
  input logic [OW-1:0]    pattern_i
);
  AST_OFF_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (pattern_i == '0 && preset_i == '0 && step_i == '0)); // R2

  AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !active_i) |=> step_i == '0); // R3

  AST_ADVANCE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && enable_i && !index_i && match_i && step_i != last_i)
    |=> step_i == IDX_W'($past(step_i) + 1'b1)); // R4

  AST_END_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && enable_i && !index_i && step_i == last_i)
    |=> ($stable(step_i) && $stable(pattern_i) && $stable(preset_i))); // R5

  AST_INDEX_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && enable_i && index_i) |=> step_i == '0); // R6

  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && enable_i && !index_i && !match_i)
    |=> ($stable(step_i) && $stable(pattern_i) && $stable(preset_i))); // R9

  AST_END_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && enable_i) |=> $stable(last_i)); // R10
endmodule

bind drum_sequencer dseq_checker #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .match_i   (match_i),
  .index_i   (index_i),
  .active_i  (active),
  .last_i    (last_idx),
  .step_i    (step_o),
  .preset_i  (preset_o),
  .pattern_i (pattern_o)
);

// File: tb/test_drum_sequencer.sv
module test_drum_sequencer;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned PW    = 32;
  localparam int unsigned OW    = 8;
  localparam int unsigned IDX_W = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enable_i = 1'b0, match_i = 1'b0, index_i = 1'b0, wr_en_i = 1'b0;
  logic [IDX_W-1:0] last_idx_i = '0, wr_addr_i = '0;
  logic [PW-1:0]    wr_preset_i = '0;
  logic [OW-1:0]    wr_pattern_i = '0;
  logic [PW-1:0]    preset_o;
  logic [OW-1:0]    pattern_o;
  logic [IDX_W-1:0] step_o;

  int vectors = 0, errors = 0, cycles = 0;

  logic [PW-1:0]    m_pre [DEPTH];
  logic [OW-1:0]    m_pat [DEPTH];
  logic             m_act;
  logic [IDX_W-1:0] m_ptr, m_last;
  logic [PW-1:0]    e_pre;
  logic [OW-1:0]    e_pat;

  always #5 clk_i = ~clk_i;

  drum_sequencer #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) i_drum_sequencer (
    .clk_i, .rst_ni, .enable_i, .match_i, .index_i, .last_idx_i,
    .wr_en_i, .wr_addr_i, .wr_preset_i, .wr_pattern_i,
    .preset_o, .pattern_o, .step_o
  );

  function automatic string ev_tag(logic en, logic m, logic ix);
    if (!en) return "R2";
    if (!m_act) return "R3";
    if (ix && m) return "R7";
    if (ix) return "R6";
    if (m && m_ptr == m_last) return "R5";
    if (m) return "R4";
    return "R9";
  endfunction

  function automatic void model_load(logic [IDX_W-1:0] p);
    m_ptr = p;
    e_pre = m_pre[p];
    e_pat = m_pat[p];
  endfunction

  task automatic compare(string tag);
    vectors++;
    if (preset_o !== e_pre || pattern_o !== e_pat || step_o !== m_ptr) begin
      errors++;
      $display("FAIL %s: preset=%h pattern=%h step=%0d, expected preset=%h pattern=%h step=%0d",
               tag, preset_o, pattern_o, step_o, e_pre, e_pat, m_ptr);
    end
  endtask

  // Called at a negedge; drives inputs, applies one edge, checks at next negedge.
  task automatic cyc(logic en, logic m, logic ix, logic [IDX_W-1:0] li,
                     logic we, logic [IDX_W-1:0] wa, logic [PW-1:0] wp,
                     logic [OW-1:0] wpat, string tag);
    string t;
    enable_i = en; match_i = m; index_i = ix; last_idx_i = li;
    wr_en_i = we; wr_addr_i = wa; wr_preset_i = wp; wr_pattern_i = wpat;
    t = (tag == "") ? ev_tag(en, m, ix) : tag;
    @(posedge clk_i);
    if (we && !en) begin
      m_pre[wa] = wp;
      m_pat[wa] = wpat;
    end
    if (!en) begin
      m_act = 1'b0; m_ptr = '0; e_pre = '0; e_pat = '0;
    end else if (!m_act) begin
      m_act = 1'b1; m_last = li; model_load('0);
    end else if (ix) begin
      model_load('0);
    end else if (m && m_ptr != m_last) begin
      model_load(m_ptr + 1'b1);
    end
    @(negedge clk_i);
    compare(t);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_pre[i] = '0;
      m_pat[i] = '0;
    end
    m_act = 1'b0; m_ptr = '0; m_last = '0; e_pre = '0; e_pat = '0;
    void'($urandom(32'd4711));

    repeat (2) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;

    // Fill table while stopped; events ignored.
    for (int i = 0; i < DEPTH; i++)
      cyc(1'b0, i[0], i[1], '0, 1'b1, IDX_W'(i), PW'(100 * (i + 1)), OW'(8'h11 * i + 1), "R8");
    cyc(1'b0, 1'b1, 1'b1, '0, 1'b0, '0, '0, '0, "R2");

    cyc(1'b1, 1'b0, 1'b0, 3'd3, 1'b0, '0, '0, '0, "R3");
    cyc(1'b1, 1'b0, 1'b0, 3'd3, 1'b0, '0, '0, '0, "R9");
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 3'd3, 1'b0, '0, '0, '0, "R4");
    cyc(1'b1, 1'b1, 1'b0, 3'd3, 1'b0, '0, '0, '0, "R5");
    cyc(1'b1, 1'b1, 1'b0, 3'd3, 1'b0, '0, '0, '0, "R5");
    cyc(1'b1, 1'b0, 1'b1, 3'd3, 1'b0, '0, '0, '0, "R6");
    cyc(1'b1, 1'b1, 1'b0, 3'd3, 1'b0, '0, '0, '0, "R4");
    cyc(1'b1, 1'b1, 1'b1, 3'd3, 1'b0, '0, '0, '0, "R7");

    // Final entry number must not follow last_idx_i while running.
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 3'd7, 1'b0, '0, '0, '0, "R10");

    // Write while running is dropped.
    cyc(1'b1, 1'b0, 1'b0, 3'd7, 1'b1, 3'd0, 32'hDEAD_BEEF, 8'hA5, "R8");
    cyc(1'b1, 1'b0, 1'b1, 3'd7, 1'b0, '0, '0, '0, "R8");
    // Write while stopped lands and shows after enable.
    cyc(1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 3'd0, 32'hCAFE_0001, 8'h5A, "R8");
    cyc(1'b1, 1'b0, 1'b0, 3'd7, 1'b0, '0, '0, '0, "R8");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 1'b0, 3'd2, 1'b0, '0, '0, '0, "");

    for (int n = 0; n < 4000; n++) begin
      logic en, m, ix, we;
      en = ($urandom % 40) != 0;
      m  = ($urandom % 3) == 0;
      ix = ($urandom % 11) == 0;
      we = ($urandom % 4) == 0;
      cyc(en, m, ix, IDX_W'($urandom), we, IDX_W'($urandom), $urandom, OW'($urandom), "");
    end
    summary();
  end
endmodule